// File: doc/BRIEF.md
# Programmable Sum-of-Products Term Array with Shared Term Steering

This block is the combinational heart of one logic block in a sum-of-products programmable device. A set of interconnect signals enters, each is offered to a wide AND plane in both polarities, and every row of that plane forms one product term from whichever literals its configuration connects. The product terms form a common pool. A per-macrocell steering mask picks any subset of the pool and ORs it into that macrocell's sum output. One term may be picked by several macrocells at once, so logic common to several outputs is built only once.

The configuration is a static bit vector driven from outside. It holds the AND-plane connections first and the steering masks after them. A macrocell may take at most a fixed number of terms. A mask that picks more than that limit raises a per-macrocell configuration-error flag, and only the lowest-indexed terms up to the limit are used. No clock and no stored state are involved: the outputs follow the current inputs and configuration.

Top module: `pt_array_alloc`

## Requirements
- R1: Literal column 2*i of each row is input i and column 2*i+1 is its complement. Row r occupies configuration bits [r*2*N_IN +: 2*N_IN], and a set bit connects that literal. A product term is the AND of its connected literals.
- R2: A product term with no literal connected evaluates to 1.
- R3: A product term connected to both polarities of the same input evaluates to 0 for every input value.
- R4: Steering mask m occupies configuration bits [N_PT*2*N_IN + m*N_PT +: N_PT], where bit t picks term t. Sum output m is the OR of the picked terms, and one term may feed several sums at once.
- R5: When mask m picks more than MAX_PT terms, over_cap[m] is 1 and only the MAX_PT lowest-indexed picked terms form sum m. Otherwise over_cap[m] is 0.
- R6: A macrocell whose mask picks no term outputs 0.
- R7: The outputs depend only on the present in_sig and cfg values, whatever values were applied earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_sig | input | N_IN | Signals from the interconnect |
| cfg | input | N_PT*2*N_IN + N_MC*N_PT | Static AND-plane connections followed by steering masks |
| sum_out | output | N_MC | Sum-of-products result per macrocell |
| over_cap | output | N_MC | Mask picks more terms than the per-cell limit |

## Verification
Some properties are checked whenever the inputs change. A row with no connections gives 1. A row holding both polarities of one input gives 0. A true literal tied to a low input forces its term low. Each cell uses no more than MAX_PT terms, and those terms are a subset of its mask. An empty mask gives a 0 output. Other behaviour can only be shown by the bench's scenarios: sums that match the expected OR under many input and configuration combinations, the truncation that drops exactly the higher-indexed surplus terms, terms shared between cells, and results that do not depend on earlier stimulus.

// File: rtl/pt_alloc_pkg.sv
// Package: sizing helpers shared by the term array and its checker.
// Assumes configuration is AND-plane rows first, steering masks after.
package pt_alloc_pkg;

    // Total configuration width for the given sizing.
    function automatic int cfg_width(input int n_in, input int n_pt, input int n_mc);
        return n_pt * 2 * n_in + n_mc * n_pt;
    endfunction

endpackage

// File: rtl/pt_and_plane.sv
// Module: pt_and_plane
// Builds both polarities of every input and forms one AND term per row.
// Assumes row r holds 2*N_IN connection bits, even columns true, odd inverted.
module pt_and_plane #(
    parameter int N_IN = 36,
    parameter int N_PT = 86,
    localparam int LIT_W = 2 * N_IN,
    localparam int AND_W = N_PT * LIT_W
) (
    input  logic [N_IN-1:0]  in_sig,
    input  logic [AND_W-1:0] and_cfg,
    output logic [N_PT-1:0]  pterm
);

    logic [LIT_W-1:0] lit;

    // Literal generation: true and complemented copy of each input.
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = in_sig[i];
        assign lit[2*i+1] = ~in_sig[i];
    end

    // Product term per row: unconnected columns read as 1.
    for (genvar r = 0; r < N_PT; r++) begin : g_row
        assign pterm[r] = &(lit | ~and_cfg[r*LIT_W +: LIT_W]);
    end

endmodule

// File: rtl/pt_steer_limit.sv
// Module: pt_steer_limit
// Keeps at most MAX_PT picked terms of one mask, lowest index first, and
// flags a mask that asks for more. Purely combinational.
module pt_steer_limit #(
    parameter int N_PT   = 86,
    parameter int MAX_PT = 16,
    localparam int CW    = $clog2(N_PT + 2)
) (
    input  logic [N_PT-1:0] sel,
    output logic [N_PT-1:0] kept,
    output logic            over
);

    logic [CW-1:0] cnt;

    // Ascending scan: a picked term is kept while fewer than MAX_PT are taken.
    always_comb begin
        cnt  = '0;
        kept = '0;
        for (int t = 0; t < N_PT; t++) begin
            kept[t] = sel[t] && (cnt < CW'(MAX_PT));
            cnt     = cnt + {{(CW-1){1'b0}}, sel[t]};
        end
        over = (cnt > CW'(MAX_PT));
    end

endmodule

// File: rtl/pt_or_plane.sv
// Module: pt_or_plane
// ORs each macrocell's kept terms out of the shared pool into its sum.
module pt_or_plane #(
    parameter int N_PT = 86,
    parameter int N_MC = 16
) (
    input  logic [N_PT-1:0]      pterm,
    input  logic [N_MC*N_PT-1:0] kept_all,
    output logic [N_MC-1:0]      sum_out
);

    // Sum per cell: an empty kept set yields 0.
    for (genvar m = 0; m < N_MC; m++) begin : g_sum
        assign sum_out[m] = |(pterm & kept_all[m*N_PT +: N_PT]);
    end

endmodule

// File: rtl/pt_array_alloc.sv
// Module: pt_array_alloc (top)
// One logic block's AND plane, per-cell term limiter and OR plane.
// Assumes cfg is static while outputs are used; no clock, no state.
module pt_array_alloc #(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_MC   = 16,
    parameter int MAX_PT = 16,
    localparam int LIT_W = 2 * N_IN,
    localparam int AND_W = N_PT * LIT_W,
    localparam int CFG_W = pt_alloc_pkg::cfg_width(N_IN, N_PT, N_MC)
) (
    input  logic [N_IN-1:0]  in_sig,
    input  logic [CFG_W-1:0] cfg,
    output logic [N_MC-1:0]  sum_out,
    output logic [N_MC-1:0]  over_cap
);

    logic [N_PT-1:0]      pterm;
    logic [N_MC*N_PT-1:0] kept_all;

    pt_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) and_i (
        .in_sig  (in_sig),
        .and_cfg (cfg[AND_W-1:0]),
        .pterm   (pterm)
    );

    // One limiter per macrocell on its own steering mask.
    for (genvar m = 0; m < N_MC; m++) begin : g_cell
        pt_steer_limit #(.N_PT(N_PT), .MAX_PT(MAX_PT)) lim_i (
            .sel  (cfg[AND_W + m*N_PT +: N_PT]),
            .kept (kept_all[m*N_PT +: N_PT]),
            .over (over_cap[m])
        );
    end

    pt_or_plane #(.N_PT(N_PT), .N_MC(N_MC)) or_i (
        .pterm    (pterm),
        .kept_all (kept_all),
        .sum_out  (sum_out)
    );

endmodule

// File: rtl/pt_array_alloc_chk.sv
// Module: pt_array_alloc_chk
// Checks term and steering rules whenever inputs settle; bound to the top.
module pt_array_alloc_chk #(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_MC   = 16,
    parameter int MAX_PT = 16,
    localparam int LIT_W = 2 * N_IN,
    localparam int AND_W = N_PT * LIT_W,
    localparam int CFG_W = pt_alloc_pkg::cfg_width(N_IN, N_PT, N_MC)
) (
    input logic [N_IN-1:0]      in_sig,
    input logic [CFG_W-1:0]     cfg,
    input logic [N_PT-1:0]      pterm,
    input logic [N_MC*N_PT-1:0] kept_all,
    input logic [N_MC-1:0]      sum_out
);

    // Term-level rules per row.
    always_comb begin
        for (int r = 0; r < N_PT; r++) begin
            a_r2_empty_row_one: assert (|cfg[r*LIT_W +: LIT_W] || pterm[r])
                else $error("R2 unconnected row %0d not 1", r);
            for (int i = 0; i < N_IN; i++) begin
                a_r3_both_pol_zero: assert (!(cfg[r*LIT_W+2*i] && cfg[r*LIT_W+2*i+1]) || !pterm[r])
                    else $error("R3 contradictory row %0d not 0", r);
                a_r1_true_lit_gate: assert (!(cfg[r*LIT_W+2*i] && !in_sig[i]) || !pterm[r])
                    else $error("R1 row %0d ignores low input %0d", r, i);
            end
        end
    end

    // Steering rules per macrocell.
    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            a_r5_cap_limit: assert ($countones(kept_all[m*N_PT +: N_PT]) <= MAX_PT)
                else $error("R5 cell %0d uses too many terms", m);
            a_r5_kept_subset: assert ((kept_all[m*N_PT +: N_PT] & ~cfg[AND_W + m*N_PT +: N_PT]) == '0)
                else $error("R5 cell %0d uses unpicked term", m);
            a_r6_empty_mask_zero: assert (|cfg[AND_W + m*N_PT +: N_PT] || !sum_out[m])
                else $error("R6 empty cell %0d not 0", m);
        end
    end

endmodule

bind pt_array_alloc pt_array_alloc_chk #(
    .N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT)
) chk_i (
    .in_sig   (in_sig),
    .cfg      (cfg),
    .pterm    (pterm),
    .kept_all (kept_all),
    .sum_out  (sum_out)
);

// File: tb/pt_array_alloc_tb.sv
// Bench: exhaustive input sweeps over a small sizing, directed and random
// configurations, expected values computed from the requirement rules.
module pt_array_alloc_tb_top;

    localparam int N_IN   = 3;
    localparam int N_PT   = 6;
    localparam int N_MC   = 4;
    localparam int MAX_PT = 2;
    localparam int LIT_W  = 2 * N_IN;
    localparam int AND_W  = N_PT * LIT_W;
    localparam int CFG_W  = AND_W + N_MC * N_PT;

    logic clk = 1'b0;
    logic [N_IN-1:0]  in_sig = '0;
    logic [CFG_W-1:0] cfg = '0;
    logic [N_MC-1:0]  sum_out;
    logic [N_MC-1:0]  over_cap;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [CFG_W-1:0] cfg_a;

    always #5 clk = ~clk;

    pt_array_alloc #(.N_IN(N_IN), .N_PT(N_PT), .N_MC(N_MC), .MAX_PT(MAX_PT)) dut_i (
        .in_sig   (in_sig),
        .cfg      (cfg),
        .sum_out  (sum_out),
        .over_cap (over_cap)
    );

    // Model of one product term from the R1 layout.
    function automatic logic m_term(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x, input int r);
        logic v = 1'b1;
        for (int i = 0; i < N_IN; i++) begin
            if (c[r*LIT_W+2*i] && !x[i]) v = 1'b0;
            if (c[r*LIT_W+2*i+1] && x[i]) v = 1'b0;
        end
        return v;
    endfunction

    // Model of one sum with the lowest-index cap.
    function automatic logic m_sum(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x, input int m);
        int n = 0;
        logic v = 1'b0;
        for (int t = 0; t < N_PT; t++) begin
            if (c[AND_W + m*N_PT + t]) begin
                if (n < MAX_PT) v = v | m_term(c, x, t);
                n++;
            end
        end
        return v;
    endfunction

    function automatic logic m_over(input logic [CFG_W-1:0] c, input int m);
        return $countones(c[AND_W + m*N_PT +: N_PT]) > MAX_PT;
    endfunction

    task automatic apply(input logic [CFG_W-1:0] c, input logic [N_IN-1:0] x);
        @(negedge clk);
        cfg = c;
        in_sig = x;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: cfg=%h in=%b actual=%b expected=%b", req, cfg, in_sig, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int m = 0; m < N_MC; m++) begin
            chk({tag, " R4 sum"}, sum_out[m], m_sum(cfg, in_sig, m));
            chk({tag, " R5 flag"}, over_cap[m], m_over(cfg, m));
        end
    endtask

    task automatic set_lit(inout logic [CFG_W-1:0] c, input int r, input int i, input bit inv);
        c[r*LIT_W + 2*i + (inv ? 1 : 0)] = 1'b1;
    endtask

    task automatic set_pick(inout logic [CFG_W-1:0] c, input int m, input int t);
        c[AND_W + m*N_PT + t] = 1'b1;
    endtask

    initial begin
        logic [CFG_W-1:0] c;
        // R6: all-zero configuration gives quiet outputs.
        apply('0, 3'b101);
        chk("R6 zero cfg sums", |sum_out, 1'b0);
        chk("R5 zero cfg flags", |over_cap, 1'b0);

        // Directed configuration.
        c = '0;
        set_lit(c, 1, 0, 0);                         // t1 = x0
        set_lit(c, 2, 1, 1);                         // t2 = ~x1
        set_lit(c, 3, 0, 0); set_lit(c, 3, 0, 1);    // t3 = x0 & ~x0
        set_lit(c, 4, 2, 0); set_lit(c, 4, 1, 0);    // t4 = x2 & x1
        set_lit(c, 5, 2, 1);                         // t5 = ~x2
        set_pick(c, 1, 1); set_pick(c, 1, 4);        // m1: t1,t4
        set_pick(c, 2, 1); set_pick(c, 2, 2);
        set_pick(c, 2, 4); set_pick(c, 2, 5);        // m2: over cap
        set_pick(c, 3, 3);                           // m3: contradictory term
        cfg_a = c;
        for (int x = 0; x < 8; x++) begin
            apply(cfg_a, 3'(x));
            chk_all("sweep A");
            chk("R6 empty mask", sum_out[0], 1'b0);
            chk("R3 contradiction", sum_out[3], 1'b0);
            chk("R5 flag set", over_cap[2], 1'b1);
            chk("R5 flag clear", over_cap[1], 1'b0);
        end
        apply(cfg_a, 3'b010);
        chk("R5 high terms dropped", sum_out[2], 1'b0);
        apply(cfg_a, 3'b110);
        chk("R1 two literal AND", sum_out[1], 1'b1);
        apply(cfg_a, 3'b001);
        chk("R4 shared term cell1", sum_out[1], 1'b1);
        chk("R4 shared term cell2", sum_out[2], 1'b1);

        // R2: unconnected row 0 steered to cell 3.
        c = '0;
        set_pick(c, 3, 0);
        for (int x = 0; x < 8; x++) begin
            apply(c, 3'(x));
            chk("R2 empty row is 1", sum_out[3], 1'b1);
        end

        // Random configurations, exhaustive inputs each.
        for (int k = 0; k < 200; k++) begin
            for (int b = 0; b < CFG_W; b++)
                c[b] = (b < AND_W) ? (($urandom % 4) == 0) : (($urandom % 3) == 0);
            for (int x = 0; x < 8; x++) begin
                apply(c, 3'(x));
                chk_all("random");
            end
        end

        // R7: same stimulus after different history gives the same result.
        apply(cfg_a, 3'b010);
        chk("R7 repeat cell2", sum_out[2], 1'b0);
        chk("R7 repeat cell1", sum_out[1], 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule